// File: doc/BRIEF.md
# Effective Address Quadrant Decoder

This block turns an effective address into a fully qualified translation context before any table walk begins. The two most significant address bits pick one of four quadrants. Each quadrant decides whether the partition ID comes from the partition register or is forced to zero. It also decides whether the process ID comes from the process register or is forced to zero. The rules differ between hypervisor mode and guest mode, and two quadrants are forbidden to a guest.

When an address cannot be qualified, the block reports a segment fault instead of a context. The fault is either an instruction segment fault, for a fetch, or a data segment fault, for a load or store. A data segment fault also carries the faulting address. An address is rejected when a reserved field just below the quadrant bits is not all zero, or when a guest uses an illegal quadrant.

The block is a single pipeline stage. A request strobe with its operands is captured on a rising clock edge. The matching response strobe and result appear on the outputs one cycle later. A new request may arrive on every cycle. There is no state machine: the register stage has exactly two conditions, idle (no strobe) and loaded (strobe), and every transition between them is taken on the clock edge that samples `req_vld`.

Top module: `eaq_decoder`

## Requirements
- R1: `rsp_vld` is high in the cycle after each cycle in which `req_vld` is high, and low otherwise. Back-to-back requests give back-to-back responses, each carrying the result for its own request.
- R2: A reserved-field violation faults and yields no context, in any quadrant and any mode. With the default 64-bit address this means any nonzero bit among bits 61 down to 52 (LSB-0 numbering); in general it is the RSV_W bits directly below the two quadrant bits.
- R3: In hypervisor mode (`req_hv`=1) with no reserved-field violation, quadrant 0 (address bits 63:62 = 00) yields a partition ID of 0 and a process ID equal to `pid_reg`. Quadrant 1 (01) yields `lpid_reg` and `pid_reg`.
- R4: In hypervisor mode, quadrant 2 (10) yields `lpid_reg` with a process ID of 0. Quadrant 3 (11) yields 0 for both IDs.
- R5: In guest mode (`req_hv`=0), quadrant 0 yields `lpid_reg` and `pid_reg`. Quadrant 3 yields `lpid_reg` with a process ID of 0.
- R6: In guest mode, quadrants 1 and 2 fault.
- R7: A fault on a fetch (`req_acc`=00) raises `rsp_iseg` and leaves `rsp_dar` at 0.
- R8: A fault on a load (01) or a store (10) raises `rsp_dseg` and puts the full effective address on `rsp_dar`. Code 11 is handled as a load.
- R9: On a fault, `rsp_err` is 0. On success it equals the `err_in` value that was sampled with the request.
- R10: In every response cycle exactly one of `rsp_ok`, `rsp_iseg` and `rsp_dseg` is high. On a fault, `rsp_lpid` and `rsp_pid` are 0. On success, `rsp_dar` is 0.
- R11: During reset and in every cycle without a response, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request strobe |
| req_ea | input | ADDR_W | Effective address |
| req_hv | input | 1 | 1 = hypervisor mode, 0 = guest mode |
| req_acc | input | 2 | Access type: 00 fetch, 01 load, 10 store |
| lpid_reg | input | LPID_W | Current partition ID register |
| pid_reg | input | PID_W | Current process ID register |
| err_in | input | ERR_W | Error code passed through on success |
| rsp_vld | output | 1 | Response strobe |
| rsp_ok | output | 1 | Context is valid |
| rsp_lpid | output | LPID_W | Qualified partition ID |
| rsp_pid | output | PID_W | Qualified process ID |
| rsp_iseg | output | 1 | Instruction segment fault |
| rsp_dseg | output | 1 | Data segment fault |
| rsp_dar | output | ADDR_W | Fault address for a data fault |
| rsp_err | output | ERR_W | Error code |

## Verification
The bench builds the block with its default parameters: a 64-bit address, 12-bit partition IDs, 20-bit process IDs and 32-bit error codes. With these values the quadrant bits sit at the very top of the address, and the reserved field covers bits 61 to 52. This exposes the whole reserved field, the full-width fault address, and register values that differ from zero in their top bits. The full sweep of four quadrants, two modes and three access codes is run back to back. Further requests set single reserved bits at both ends of the field, and idle gaps show the strobe dropping.

// File: rtl/eaq_pkg.sv
package eaq_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_RSVD  = 2'b11
    } eaq_acc_e;

    typedef enum logic [1:0] {
        QD_0 = 2'b00,
        QD_1 = 2'b01,
        QD_2 = 2'b10,
        QD_3 = 2'b11
    } eaq_quad_e;
endpackage

// File: rtl/eaq_quad_map.sv
module eaq_quad_map
    import eaq_pkg::*;
#(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic              hv,
    input  logic [1:0]        quad,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    output logic              legal,
    output logic [LPID_W-1:0] lpid,
    output logic [PID_W-1:0]  pid
);
    logic use_lpid;
    logic use_pid;

    always_comb begin
        legal    = 1'b1;
        use_lpid = 1'b0;
        use_pid  = 1'b0;
        if (hv) begin
            unique case (eaq_quad_e'(quad))
                QD_0: use_pid = 1'b1;
                QD_1: begin use_lpid = 1'b1; use_pid = 1'b1; end
                QD_2: use_lpid = 1'b1;
                QD_3: ;
            endcase
        end else begin
            unique case (eaq_quad_e'(quad))
                QD_0: begin use_lpid = 1'b1; use_pid = 1'b1; end
                QD_1, QD_2: legal = 1'b0;
                QD_3: use_lpid = 1'b1;
            endcase
        end
    end

    assign lpid = use_lpid ? lpid_reg : '0;
    assign pid  = use_pid  ? pid_reg  : '0;
endmodule

// File: rtl/eaq_fault_class.sv
module eaq_fault_class
    import eaq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int ERR_W  = 32
) (
    input  logic              fault,
    input  logic [1:0]        acc,
    input  logic [ADDR_W-1:0] ea,
    input  logic [ERR_W-1:0]  err_in,
    output logic              iseg,
    output logic              dseg,
    output logic [ADDR_W-1:0] dar,
    output logic [ERR_W-1:0]  err
);
    logic is_fetch;

    assign is_fetch = (eaq_acc_e'(acc) == ACC_FETCH);
    assign iseg     = fault && is_fetch;
    assign dseg     = fault && !is_fetch;
    assign dar      = dseg ? ea : '0;
    assign err      = fault ? '0 : err_in;
endmodule

// File: rtl/eaq_decoder.sv
module eaq_decoder
    import eaq_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int RSV_W  = 10,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int ERR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic              req_hv,
    input  logic [1:0]        req_acc,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    input  logic [ERR_W-1:0]  err_in,
    output logic              rsp_vld,
    output logic              rsp_ok,
    output logic [LPID_W-1:0] rsp_lpid,
    output logic [PID_W-1:0]  rsp_pid,
    output logic              rsp_iseg,
    output logic              rsp_dseg,
    output logic [ADDR_W-1:0] rsp_dar,
    output logic [ERR_W-1:0]  rsp_err
);
    localparam int QUAD_HI = ADDR_W - 1;
    localparam int RSV_HI  = ADDR_W - 3;

    logic [1:0]        quad;
    logic              stray;
    logic              legal;
    logic              fault;
    logic [LPID_W-1:0] map_lpid;
    logic [PID_W-1:0]  map_pid;
    logic              nx_iseg;
    logic              nx_dseg;
    logic [ADDR_W-1:0] nx_dar;
    logic [ERR_W-1:0]  nx_err;

    assign quad  = req_ea[QUAD_HI -: 2];
    assign stray = |req_ea[RSV_HI -: RSV_W];
    assign fault = stray || !legal;

    eaq_quad_map #(.LPID_W(LPID_W), .PID_W(PID_W)) u_map (
        .hv       (req_hv),
        .quad     (quad),
        .lpid_reg (lpid_reg),
        .pid_reg  (pid_reg),
        .legal    (legal),
        .lpid     (map_lpid),
        .pid      (map_pid)
    );

    eaq_fault_class #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_fault (
        .fault  (fault),
        .acc    (req_acc),
        .ea     (req_ea),
        .err_in (err_in),
        .iseg   (nx_iseg),
        .dseg   (nx_dseg),
        .dar    (nx_dar),
        .err    (nx_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_ok   <= 1'b0;
            rsp_lpid <= '0;
            rsp_pid  <= '0;
            rsp_iseg <= 1'b0;
            rsp_dseg <= 1'b0;
            rsp_dar  <= '0;
            rsp_err  <= '0;
        end else begin
            rsp_vld  <= req_vld;
            rsp_ok   <= req_vld && !fault;
            rsp_lpid <= (req_vld && !fault) ? map_lpid : '0;
            rsp_pid  <= (req_vld && !fault) ? map_pid  : '0;
            rsp_iseg <= req_vld && nx_iseg;
            rsp_dseg <= req_vld && nx_dseg;
            rsp_dar  <= req_vld ? nx_dar : '0;
            rsp_err  <= req_vld ? nx_err : '0;
        end
    end
endmodule

// File: rtl/eaq_decoder_chk.sv
module eaq_decoder_chk #(
    parameter int ADDR_W = 64,
    parameter int RSV_W  = 10,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int ERR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic [ADDR_W-1:0] req_ea,
    input logic              req_hv,
    input logic [1:0]        req_acc,
    input logic              rsp_vld,
    input logic              rsp_ok,
    input logic [LPID_W-1:0] rsp_lpid,
    input logic [PID_W-1:0]  rsp_pid,
    input logic              rsp_iseg,
    input logic              rsp_dseg,
    input logic [ADDR_W-1:0] rsp_dar,
    input logic [ERR_W-1:0]  rsp_err
);
    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld && !rsp_ok && !rsp_iseg && !rsp_dseg);
    p_stray_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && (|req_ea[ADDR_W-3 -: RSV_W]) |=> !rsp_ok);
    p_guest_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && !req_hv && (req_ea[ADDR_W-1] != req_ea[ADDR_W-2]) |=> !rsp_ok);
    p_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && req_acc == 2'b00 |=> !rsp_dseg);
    p_dar_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dseg |-> rsp_dar == $past(req_ea));
    p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_iseg || rsp_dseg) |-> rsp_err == '0);
    p_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $countones({rsp_ok, rsp_iseg, rsp_dseg}) == 1);
    p_ctx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ok |-> rsp_lpid == '0 && rsp_pid == '0);
endmodule

bind eaq_decoder eaq_decoder_chk #(
    .ADDR_W(ADDR_W), .RSV_W(RSV_W), .LPID_W(LPID_W), .PID_W(PID_W), .ERR_W(ERR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_ea(req_ea),
    .req_hv(req_hv), .req_acc(req_acc), .rsp_vld(rsp_vld), .rsp_ok(rsp_ok),
    .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid), .rsp_iseg(rsp_iseg),
    .rsp_dseg(rsp_dseg), .rsp_dar(rsp_dar), .rsp_err(rsp_err)
);

// File: tb/tb_eaq_decoder.sv
module tb_eaq_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [63:0] req_ea = '0;
    logic        req_hv = 1'b0;
    logic [1:0]  req_acc = '0;
    logic [11:0] lpid_reg = 12'hA5C;
    logic [19:0] pid_reg = 20'h8_1F3D;
    logic [31:0] err_in = 32'hDEAD_0001;
    logic        rsp_vld, rsp_ok, rsp_iseg, rsp_dseg;
    logic [11:0] rsp_lpid;
    logic [19:0] rsp_pid;
    logic [63:0] rsp_dar;
    logic [31:0] rsp_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // expected response for the request driven in the previous cycle
    logic        e_vld, e_ok, e_iseg, e_dseg;
    logic [11:0] e_lpid;
    logic [19:0] e_pid;
    logic [63:0] e_dar;
    logic [31:0] e_err;
    string       e_tag;

    always #4 clk = ~clk;

    eaq_decoder dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_ea(req_ea),
        .req_hv(req_hv), .req_acc(req_acc), .lpid_reg(lpid_reg),
        .pid_reg(pid_reg), .err_in(err_in), .rsp_vld(rsp_vld),
        .rsp_ok(rsp_ok), .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid),
        .rsp_iseg(rsp_iseg), .rsp_dseg(rsp_dseg), .rsp_dar(rsp_dar),
        .rsp_err(rsp_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural model of the requirements
    task automatic model(input bit v, input logic [63:0] ea, input bit hv, input logic [1:0] acc);
        int  q;
        bit  ok;
        bit  useL, useP;
        q    = int'(ea[63:62]);
        ok   = 1;
        useL = 0;
        useP = 0;
        e_tag = "R11";
        if (v) begin
            if (hv) begin
                e_tag = (q < 2) ? "R3" : "R4";
                useL  = (q == 1 || q == 2);
                useP  = (q == 0 || q == 1);
            end else begin
                e_tag = "R5";
                if (q == 1 || q == 2) begin ok = 0; e_tag = "R6"; end
                useL = 1;
                useP = (q == 0);
            end
            if (ea[61:52] != 0) begin ok = 0; e_tag = "R2"; end
        end
        e_vld  = v;
        e_ok   = v && ok;
        e_lpid = (e_ok && useL) ? lpid_reg : 12'h0;
        e_pid  = (e_ok && useP) ? pid_reg : 20'h0;
        e_iseg = v && !ok && acc == 2'b00;
        e_dseg = v && !ok && acc != 2'b00;
        e_dar  = e_dseg ? ea : 64'h0;
        e_err  = e_ok ? err_in : 32'h0;
    endtask

    task automatic compare();
        string fx;
        fx = e_iseg ? "R7" : (e_dseg ? "R8" : e_tag);
        chk("R1",  rsp_vld,  e_vld,  "rsp_vld");
        chk(e_tag, rsp_ok,   e_ok,   "rsp_ok");
        chk(e_tag, rsp_lpid, e_lpid, "rsp_lpid");
        chk(e_tag, rsp_pid,  e_pid,  "rsp_pid");
        chk(fx,    rsp_iseg, e_iseg, "rsp_iseg");
        chk(fx,    rsp_dseg, e_dseg, "rsp_dseg");
        chk(fx,    rsp_dar,  e_dar,  "rsp_dar R10");
        chk("R9",  rsp_err,  e_err,  "rsp_err");
        if (rsp_vld)
            chk("R10", $countones({rsp_ok, rsp_iseg, rsp_dseg}), 1, "one-hot result");
    endtask

    // one cycle: drive at negedge, check at next negedge
    task automatic step(input bit v, input logic [63:0] ea, input bit hv, input logic [1:0] acc);
        req_vld = v; req_ea = ea; req_hv = hv; req_acc = acc;
        model(v, ea, hv, acc);
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        model(0, '0, 0, '0);
        compare();
        rst_n = 1'b1;
        @(negedge clk);
        compare();
        // full sweep: quadrant x mode x access, back to back (R1)
        for (int hv = 0; hv < 2; hv++)
            for (int q = 0; q < 4; q++)
                for (int a = 0; a < 3; a++)
                    step(1, {2'(q), 10'h0, 52'h0_1234_5678_9ABC} ^ 64'(a * 8), hv[0], 2'(a));
        step(0, '0, 0, '0); // R1 idle gap
        // R2 stray reserved bits, both ends of field, legal quadrants
        step(1, 64'h0010_0000_0000_1000, 1, 2'b01);
        step(1, 64'h2000_0000_0000_0040, 1, 2'b00);
        step(1, 64'hC020_0000_0000_0800, 0, 2'b10);
        step(1, 64'h3FF0_0000_0000_0000, 0, 2'b00);
        step(1, 64'h000F_FFFF_FFFF_FFFF, 1, 2'b01); // below field: legal
        // R8 access code 11 treated as load
        step(1, 64'h4000_0000_0000_ABCD, 0, 2'b11);
        // register changes between requests
        lpid_reg = 12'hFFF; pid_reg = 20'hFFFFF; err_in = 32'h1234_5678;
        step(1, 64'h4000_0000_0000_0010, 1, 2'b10);
        step(1, 64'hC000_0000_0000_0010, 0, 2'b01);
        step(0, '0, 0, '0);
        step(0, '0, 0, '0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule